// File: doc/BRIEF.md
# Dual-Channel Display FIFO Clock Divider

This block makes a slower pixel-rate timing signal for each display FIFO channel from one of several parent clocks. Every channel has its own control word. The word selects the parent, picks an internal or external timing source, turns on a divide-by-1 pass-through, and holds a divider code. The actual ratio is the code plus two. Two channels are built from the same logic, and each channel keeps its own control word.

The block is written for a single system clock domain. Parent clocks enter as one-cycle clock-enable ticks, one per parent period. Each channel drives two outputs, both registered:
- a divided clock level, and
- a one-cycle enable pulse at the start of every output period.

Software writes control words through a simple write port, in one of two ways:
- a full write replaces the whole word;
- a divider-only write clears the pass-through bit and the divider code, then applies new values for those two fields only.

A new ratio never cuts the period that is already running. It is latched only at the next period boundary.

Top module: `pixclk_divider`

## Requirements
- R1: With pass-through off, a channel's enable pulse fires once every N ticks of its selected source, where N is the divider code (bits [5:0] of the control word) plus 2. Codes 0 to 63 give ratios 2 to 65.
- R2: With pass-through off, the divided clock level is high for ceil(N/2) source ticks and low for floor(N/2) ticks. It rises in the same cycle as the enable pulse, and it changes only in the cycle after a source tick.
- R3: When the pass-through bit (bit 6) is in effect, both the divided clock and the enable pulse equal the selected source tick delayed by one cycle, whatever the divider code holds.
- R4: Synchronous active-high reset has these effects:
  - every control word reads 0x200: source 2 (the LCD PLL), bit 7 = 0, bit 6 = 0, code 0;
  - both outputs are held low;
  - once reset is released, each channel divides the external tick by 2.
- R5: Bit 7 picks the timing source. When it is 1, the channel uses parent tick `src_tick[sel]`, where sel is bits [9:8]. When it is 0, the channel uses `ext_tick`.
- R6: A full write (`wr_div_only` = 0) stores all 10 bits of `wr_data` into the addressed channel's word. `rd_data` returns the word of channel `rd_ch` one cycle after `rd_ch` is applied.
- R7: A divider-only write (`wr_div_only` = 1) replaces bits [6:0] from `wr_data` and keeps bits [9:7] of the stored word.
- R8: A changed code or pass-through bit takes effect only at the end of the output period in progress. That period completes at the old ratio.
- R9: The channels are independent. A write to one channel leaves the other channel's word and output timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One enable tick per parent clock period, per parent source |
| ext_tick | input | 1 | Enable tick of the external timing source |
| wr_en | input | 1 | Control word write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_div_only | input | 1 | 1: update only pass-through and code; 0: full word |
| wr_data | input | 10 | Write data: sel[9:8], internal[7], bypass[6], code[5:0] |
| rd_ch | input | 1 | Channel to read back |
| rd_data | output | 10 | Registered control word of channel `rd_ch` |
| div_clk | output | 2 | Divided clock level per channel |
| div_pulse | output | 2 | One-cycle enable at each output period start, per channel |

## Verification
A channel whose phase counter or latched ratio is wrong shows a pulse spacing other than N ticks, or a high time other than ceil(N/2). This appears within one output period, and at the latest two periods after any reconfiguration. A broken boundary latch makes the period that is running when a write arrives take the new length instead of finishing at the old one. A wrong field merge in the register file shows at the next readback, one cycle after `rd_ch` is set. A wrong source mux shows as a period scaled by the wrong tick spacing.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  localparam int CODE_W  = 6;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 1 << SEL_W;

  // Field order matters: software decodes sel[9:8], internal[7], bypass[6], code[5:0]
  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              internal;
    logic              bypass;
    logic [CODE_W-1:0] code;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/pixclk_cfg_regs.sv
module pixclk_cfg_regs
  import pixclk_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int LCD_SRC = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic             wr_div_only,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [CFG_W-1:0] rd_data,
  output chan_cfg_t        cfg_o [NUM_CH]
);
  localparam chan_cfg_t RESET_CFG = '{sel: SEL_W'(LCD_SRC), internal: 1'b0,
                                      bypass: 1'b0, code: '0};

  chan_cfg_t wr_word;
  assign wr_word = chan_cfg_t'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) cfg_o[i] <= RESET_CFG;
      rd_data <= '0;
    end else begin
      if (wr_en && (int'(wr_ch) < NUM_CH)) begin
        if (wr_div_only) begin
          cfg_o[wr_ch].bypass <= wr_word.bypass;
          cfg_o[wr_ch].code   <= wr_word.code;
        end else begin
          cfg_o[wr_ch] <= wr_word;
        end
      end
      if (int'(rd_ch) < NUM_CH) rd_data <= cfg_o[rd_ch];
      else                      rd_data <= '0;
    end
  end
endmodule

// File: rtl/pixclk_src_mux.sv
module pixclk_src_mux
  import pixclk_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               ext_tick,
  input  logic [SEL_W-1:0]   sel,
  input  logic               internal,
  output logic               tick_o
);
  always_comb begin
    if (internal) tick_o = src_tick[sel];
    else          tick_o = ext_tick;
  end
endmodule

// File: rtl/pixclk_div_core.sv
module pixclk_div_core
  import pixclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_in,
  input  logic              bypass_in,
  output logic              clk_o,
  output logic              pulse_o,
  output logic              act_bypass_o
);
  localparam int CNT_W = CODE_W + 1;   // holds ratios up to 2^CODE_W + 1

  logic [CNT_W-1:0]  phase;
  logic [CODE_W-1:0] act_code;
  logic [CNT_W-1:0]  last_phase;
  logic [CNT_W-1:0]  hi_len;
  logic              at_end;

  assign last_phase   = {1'b0, act_code} + CNT_W'(1);
  assign hi_len       = CNT_W'(({1'b0, act_code} + CNT_W'(3)) >> 1);
  assign at_end       = act_bypass_o || (phase == last_phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= '0;
      act_code     <= '0;
      act_bypass_o <= 1'b0;
      clk_o        <= 1'b0;
      pulse_o      <= 1'b0;
    end else begin
      pulse_o <= tick && (phase == '0);
      if (act_bypass_o)  clk_o <= tick;
      else if (tick)     clk_o <= (phase < hi_len);
      if (tick) begin
        if (at_end) begin
          phase        <= '0;
          act_code     <= code_in;
          act_bypass_o <= bypass_in;
        end else begin
          phase <= phase + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider
  import pixclk_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int LCD_SRC = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               ext_tick,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic               wr_div_only,
  input  logic [CFG_W-1:0]   wr_data,
  input  logic [CH_W-1:0]    rd_ch,
  output logic [CFG_W-1:0]   rd_data,
  output logic [NUM_CH-1:0]  div_clk,
  output logic [NUM_CH-1:0]  div_pulse
);
  chan_cfg_t         cfg [NUM_CH];
  logic [NUM_CH-1:0] ch_tick;
  logic [NUM_CH-1:0] ch_act_byp;

  pixclk_cfg_regs #(.NUM_CH(NUM_CH), .LCD_SRC(LCD_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_div_only(wr_div_only), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .cfg_o(cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pixclk_src_mux u_mux (
      .src_tick(src_tick), .ext_tick(ext_tick),
      .sel(cfg[c].sel), .internal(cfg[c].internal), .tick_o(ch_tick[c])
    );
    pixclk_div_core u_core (
      .clk(clk), .rst(rst), .tick(ch_tick[c]),
      .code_in(cfg[c].code), .bypass_in(cfg[c].bypass),
      .clk_o(div_clk[c]), .pulse_o(div_pulse[c]), .act_bypass_o(ch_act_byp[c])
    );
  end
endmodule

// File: rtl/pixclk_divider_checker.sv
module pixclk_divider_checker
  import pixclk_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CH_W-1:0]   wr_ch,
  input logic              wr_div_only,
  input logic [CFG_W-1:0]  wr_data,
  input chan_cfg_t         cfg [NUM_CH],
  input logic [NUM_CH-1:0] ch_tick,
  input logic [NUM_CH-1:0] ch_act_byp,
  input logic [NUM_CH-1:0] div_clk,
  input logic [NUM_CH-1:0] div_pulse
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_pulse_after_tick_R1: assert property (@(posedge clk) disable iff (rst)
      div_pulse[g] |-> $past(ch_tick[g]));

    assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
      $past(!ch_tick[g] && !ch_act_byp[g]) |-> $stable(div_clk[g]));

    assert_bypass_follow_R3: assert property (@(posedge clk) disable iff (rst)
      $past(ch_act_byp[g]) |->
        (div_clk[g] == $past(ch_tick[g])) && (div_pulse[g] == $past(ch_tick[g])));

    assert_full_write_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_div_only && wr_ch == CH_W'(g)) |=> (cfg[g] == $past(wr_data)));

    assert_div_write_merge_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_div_only && wr_ch == CH_W'(g)) |=>
        (cfg[g].sel == $past(cfg[g].sel)) && (cfg[g].internal == $past(cfg[g].internal)) &&
        (cfg[g].code == $past(wr_data[CODE_W-1:0])) && (cfg[g].bypass == $past(wr_data[CODE_W])));

    assert_other_ch_kept_R9: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_ch == CH_W'(g)) |=> $stable(cfg[g]));
  end
endmodule

bind pixclk_divider pixclk_divider_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_div_only(wr_div_only),
  .wr_data(wr_data), .cfg(cfg), .ch_tick(ch_tick), .ch_act_byp(ch_act_byp),
  .div_clk(div_clk), .div_pulse(div_pulse)
);

// File: tb/test_pixclk_divider.sv
`timescale 1ns/1ps
module test_pixclk_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src_tick = '0;
  logic       ext_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_ch = '0;
  logic       wr_div_only = 1'b0;
  logic [9:0] wr_data = '0;
  logic [0:0] rd_ch = '0;
  logic [9:0] rd_data;
  logic [1:0] div_clk;
  logic [1:0] div_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  pixclk_divider i_pixclk_divider (
    .clk(clk), .rst(rst), .src_tick(src_tick), .ext_tick(ext_tick),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_div_only(wr_div_only), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .div_clk(div_clk), .div_pulse(div_pulse)
  );

  always #2.5 clk = ~clk;

  // Tick sources: spacing 1, 2, 3, 5 cycles; external every cycle. Updated 1 ns after negedge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      cyc++;
      src_tick[0] = 1'b1;
      src_tick[1] = (cyc % 2 == 0);
      src_tick[2] = (cyc % 3 == 0);
      src_tick[3] = (cyc % 5 == 0);
      ext_tick    = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input int ch, input bit div_only, input logic [9:0] data);
    wr_en = 1'b1; wr_ch = 1'(ch); wr_div_only = div_only; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_div_only = 1'b0;
  endtask

  task automatic do_read(input int ch, output logic [9:0] val);
    rd_ch = 1'(ch);
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic wait_pulse(input int ch, input string tag);
    for (int i = 0; i < 2000; i++) begin
      if (div_pulse[ch]) return;
      @(negedge clk);
    end
    check(1'b0, tag, 0, 1);
  endtask

  // Returns period and high count of one output period starting at a pulse.
  task automatic measure(input int ch, input string tag, output int per, output int hi);
    wait_pulse(ch, tag);
    per = 0; hi = 0;
    for (int i = 0; i < 2000; i++) begin
      if (div_clk[ch]) hi++;
      per++;
      @(negedge clk);
      if (div_pulse[ch]) break;
    end
  endtask

  task automatic settle(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      wait_pulse(ch, "settle");
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [9:0] v;
    int per, hi;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(div_clk == 2'b00 && div_pulse == 2'b00, "R4 outputs low in reset", int'({div_clk, div_pulse}), 0);
    end
    rst = 1'b0;
    do_read(0, v); check(v == 10'h200, "R4 ch0 reset word", v, 10'h200);
    do_read(1, v); check(v == 10'h200, "R4 ch1 reset word", v, 10'h200);
    settle(0, 1);
    measure(0, "R4 default ratio", per, hi);
    check(per == 2, "R4 default period", per, 2);
    check(hi == 1, "R4 default high", hi, 1);
  endtask

  task automatic t_ratios;
    int codes [5] = '{0, 1, 2, 7, 63};
    int per, hi;
    foreach (codes[i]) begin
      do_write(0, 1'b0, 10'h080 | 10'(codes[i]));
      settle(0, 2);
      measure(0, "R1 ratio", per, hi);
      check(per == codes[i] + 2, "R1 period = code+2", per, codes[i] + 2);
      check(hi == (codes[i] + 3) / 2, "R2 high time", hi, (codes[i] + 3) / 2);
    end
  endtask

  task automatic t_select;
    int sp [4] = '{1, 2, 3, 5};
    int per, hi;
    for (int s = 1; s < 4; s++) begin
      do_write(0, 1'b0, 10'((s << 8) | 10'h081));
      settle(0, 2);
      measure(0, "R5 source", per, hi);
      check(per == 3 * sp[s], "R5 internal source period", per, 3 * sp[s]);
      check(hi == 2 * sp[s], "R2 high time with slow source", hi, 2 * sp[s]);
    end
    do_write(0, 1'b0, 10'h301);
    settle(0, 2);
    measure(0, "R5 external", per, hi);
    check(per == 3, "R5 external source period", per, 3);
  endtask

  task automatic t_bypass;
    int per, hi;
    int bad = 0;
    do_write(0, 1'b0, 10'h1D1);  // sel 1, internal, bypass, code 17
    settle(0, 2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (div_clk[0] != src_tick[1] || div_pulse[0] != src_tick[1]) bad++;
    end
    check(bad == 0, "R3 bypass follows source", bad, 0);
    do_write(0, 1'b1, 10'h002);  // clear bypass, code 2
    settle(0, 2);
    measure(0, "R3 leave bypass", per, hi);
    check(per == 8, "R3 code ignored in bypass, used after", per, 8);
  endtask

  task automatic t_boundary;
    int t0, t1, t2, per, hi;
    do_write(0, 1'b0, 10'h083);  // sel 0, N = 5
    settle(0, 2);
    wait_pulse(0, "R8 sync");
    t0 = cyc;
    do_write(0, 1'b1, 10'h000);  // N = 2 mid-period
    wait_pulse(0, "R8 first");
    t1 = cyc;
    @(negedge clk);
    wait_pulse(0, "R8 second");
    t2 = cyc;
    check(t1 - t0 == 5, "R8 running period keeps old ratio", t1 - t0, 5);
    check(t2 - t1 == 2, "R8 new ratio after boundary", t2 - t1, 2);
    do_write(0, 1'b0, 10'h083);
    settle(0, 2);
    wait_pulse(0, "R8 sync bypass");
    t0 = cyc;
    do_write(0, 1'b1, 10'h040);  // bypass mid-period
    wait_pulse(0, "R8 bypass first");
    t1 = cyc;
    check(t1 - t0 == 5, "R8 bypass waits for boundary", t1 - t0, 5);
    measure(0, "R8 bypass rate", per, hi);
    check(per == 1, "R8 bypass rate after boundary", per, 1);
  endtask

  task automatic t_writes;
    logic [9:0] v;
    do_write(1, 1'b0, 10'h385);
    do_read(1, v); check(v == 10'h385, "R6 full write readback", v, 10'h385);
    do_write(1, 1'b1, 10'h142);
    do_read(1, v); check(v == 10'h3C2, "R7 divider-only merge", v, 10'h3C2);
  endtask

  task automatic t_indep;
    logic [9:0] v;
    int per, hi;
    do_write(0, 1'b0, 10'h080);  // ch0: src0, N = 2
    do_write(1, 1'b0, 10'h282);  // ch1: src2, N = 4
    settle(0, 2); settle(1, 2);
    measure(0, "R9 ch0", per, hi);
    check(per == 2, "R9 ch0 period", per, 2);
    measure(1, "R9 ch1", per, hi);
    check(per == 12, "R9 ch1 period", per, 12);
    do_write(1, 1'b0, 10'h0C0);
    do_read(0, v); check(v == 10'h080, "R9 ch0 word untouched", v, 10'h080);
    settle(0, 1);
    measure(0, "R9 ch0 after ch1 write", per, hi);
    check(per == 2, "R9 ch0 timing untouched", per, 2);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ratios();
    t_select();
    t_bypass();
    t_boundary();
    t_writes();
    t_indep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule